// File: doc/BRIEF.md
# Incremental Hebbian Weight Update Engine

This block stores bipolar patterns, one at a time, into the symmetric coupling matrix of a fully connected oscillator network. Each pattern bit stands for a neuron state, where 1 means +1 and 0 means -1. A learn strobe latches the pattern. The engine then walks every neuron pair with row < column, one pair per clock. For each pair it adds the product of the two states to a wide signed accumulator that is private to that pair. The update depends only on the two neurons of the pair.

The accumulator is then clamped to the configured narrow signed weight width, which is 3, 4 or 5 bits. The result is written to both mirror cells of the weight matrix in the same cycle. Diagonal cells are never written and stay at zero. Weights from earlier patterns stay in the matrix, so nothing is presented again.

While an update runs, the engine holds the oscillator array in reset. When the update finishes it raises a one-cycle done pulse. A clear strobe zeroes every weight and accumulator. The oscillator array reads the matrix through a combinational row/column port.

Top module: `hebb_learn_engine`

## Requirements
- R1: After reset, every weight reads 0, and busy_o, osc_hold_o and done_o are low.
- R2: Each accepted pattern changes the accumulator of every pair i<j by +1 where bits i and j are equal and by -1 where they differ. Bit value 1 means +1 and 0 means -1. Earlier contributions are kept, so the matrix is the sum over all learned patterns.
- R3: At all times w[i][j] equals w[j][i], and every diagonal weight w[i][i] is 0.
- R4: A stored weight is its pair's accumulator clamped to [-2^(W-1), 2^(W-1)-1]. The accumulator keeps counting past that range, so a saturated weight leaves saturation only after enough opposing patterns.
- R5: Each accumulator clamps at its own limits [-2^(ACC_W-1), 2^(ACC_W-1)-1] and never wraps.
- R6: A learn strobe taken while idle raises busy_o and osc_hold_o on the next clock edge. Pairs are processed in row-major upper-triangle order, one per cycle, so busy_o stays high for exactly N(N-1)/2 cycles. done_o pulses for one cycle on the edge where busy_o falls.
- R7: A learn strobe that arrives while busy_o is high is ignored. It does not restart the update and does not change any weight.
- R8: A clear strobe while idle zeroes all weights and accumulators in one cycle. A clear strobe while busy is ignored. When clear and learn are strobed together while idle, the clear is taken and the learn is dropped.
- R9: rd_weight_o shows the weight at (rd_row_i, rd_col_i) in the same cycle as the address, with no register on the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| learn_i | input | 1 | Strobe: learn pattern_i |
| clear_i | input | 1 | Strobe: zero all weights |
| pattern_i | input | N | Bipolar pattern, 1 = +1, 0 = -1 |
| rd_row_i | input | IDX_W | Read row index |
| rd_col_i | input | IDX_W | Read column index |
| rd_weight_o | output | W | Signed weight at the read address |
| busy_o | output | 1 | Update in progress |
| osc_hold_o | output | 1 | Holds the oscillator array in reset during an update |
| done_o | output | 1 | One-cycle pulse when an update finishes |

## Verification
The assertions run on every cycle. They check that the mirror cells stay equal and the diagonal stays zero. They check that an accumulator never moves by more than one step per cycle, so it cannot wrap. They also check that the pair walker advances one pair per cycle in upper-triangle order, cannot be restarted mid-update, and ends with a single done pulse. The scenarios are needed to show the actual weight values after sequences of patterns. These cover incremental sums across patterns, the narrow clamp and recovery from it, accumulator saturation after long runs, and the exact busy length. They also show that learn or clear strobes during an update, and a clear given together with a learn, leave the expected matrix.

// File: rtl/hebb_pkg.sv
package hebb_pkg;

   typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

   function automatic int pair_total(input int n);
      return (n * (n - 1)) / 2;
   endfunction

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/hebb_pair_seq.sv
module hebb_pair_seq
   import hebb_pkg::*;
#(
   parameter int N     = 8,
   parameter int IDX_W = 3,
   parameter int PW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             learn_i,
   input  logic             clear_i,
   output logic             start_o,
   output logic             clr_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] row_o,
   output logic [IDX_W-1:0] col_o,
   output logic [PW-1:0]    pair_o
);

   seq_state_e       state_q;
   logic [IDX_W-1:0] row_q, col_q;
   logic [PW-1:0]    pair_q;
   logic             done_q;
   logic             last_pair;

   assign last_pair = (row_q == IDX_W'(N - 2)) && (col_q == IDX_W'(N - 1));
   assign start_o   = learn_i && !clear_i && (state_q == ST_IDLE);
   assign clr_o     = clear_i && (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         pair_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_o) begin
                  state_q <= ST_RUN;
                  row_q   <= '0;
                  col_q   <= IDX_W'(1);
                  pair_q  <= '0;
               end
            end
            ST_RUN: begin
               if (last_pair) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  pair_q <= pair_q + 1'b1;
                  if (col_q == IDX_W'(N - 1)) begin
                     row_q <= row_q + 1'b1;
                     col_q <= row_q + IDX_W'(2);
                  end else begin
                     col_q <= col_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q == ST_RUN);
   assign done_o = done_q;
   assign row_o  = row_q;
   assign col_o  = col_q;
   assign pair_o = pair_q;

   // R6: done is a single pulse following the last busy cycle
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == ST_IDLE) && $past(state_q == ST_RUN));

   // R6: one pair per cycle in upper-triangle order
   a_r6_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !last_pair) |=> (pair_q == PW'($past(pair_q) + 1'b1)));

   a_r6_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (row_q < col_q));

   // R7: an update in progress cannot be restarted or cut short
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !last_pair) |=> (state_q == ST_RUN) && (pair_q != '0));

endmodule

// File: rtl/hebb_acc_bank.sv
module hebb_acc_bank
   import hebb_pkg::*;
#(
   parameter int P     = 28,
   parameter int PW    = 5,
   parameter int ACC_W = 8,
   parameter int W     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                en_i,
   input  logic [PW-1:0]       pair_i,
   input  logic                bit_a_i,
   input  logic                bit_b_i,
   output logic signed [W-1:0] w_nxt_o
);

   localparam int AMAX = (2 ** (ACC_W - 1)) - 1;
   localparam int AMIN = -(2 ** (ACC_W - 1));
   localparam int WMAX = (2 ** (W - 1)) - 1;
   localparam int WMIN = -(2 ** (W - 1));

   logic signed [ACC_W-1:0] acc_q [P];
   logic signed [ACC_W-1:0] acc_nxt;

   always_comb begin
      int cur;
      int nxt;
      cur = 0;
      if (int'(pair_i) < P) cur = int'(acc_q[pair_i]);
      nxt     = clamp_int(cur + ((bit_a_i == bit_b_i) ? 1 : -1), AMIN, AMAX);
      acc_nxt = ACC_W'(nxt);
      w_nxt_o = W'(clamp_int(nxt, WMIN, WMAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < P; p++) acc_q[p] <= '0;
      end else if (clr_i) begin
         for (int p = 0; p < P; p++) acc_q[p] <= '0;
      end else if (en_i && (int'(pair_i) < P)) begin
         acc_q[pair_i] <= acc_nxt;
      end
   end

   for (genvar p = 0; p < P; p++) begin : g_acc_chk
      // R5: outside a clear an accumulator moves by at most one step, so it never wraps
      a_r5_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(clr_i) |->
            ((int'(acc_q[p]) - int'($past(acc_q[p]))) <= 1) &&
            ((int'(acc_q[p]) - int'($past(acc_q[p]))) >= -1));
   end

endmodule

// File: rtl/hebb_weight_mat.sv
module hebb_weight_mat #(
   parameter int N     = 8,
   parameter int IDX_W = 3,
   parameter int W     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                wr_en_i,
   input  logic [IDX_W-1:0]    wr_row_i,
   input  logic [IDX_W-1:0]    wr_col_i,
   input  logic signed [W-1:0] wr_w_i,
   input  logic [IDX_W-1:0]    rd_row_i,
   input  logic [IDX_W-1:0]    rd_col_i,
   output logic signed [W-1:0] rd_w_o
);

   logic signed [W-1:0] mat_q [N][N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) mat_q[r][c] <= '0;
      end else if (clr_i) begin
         for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) mat_q[r][c] <= '0;
      end else if (wr_en_i && (wr_row_i != wr_col_i) &&
                   (int'(wr_row_i) < N) && (int'(wr_col_i) < N)) begin
         mat_q[wr_row_i][wr_col_i] <= wr_w_i;
         mat_q[wr_col_i][wr_row_i] <= wr_w_i;
      end
   end

   always_comb begin
      rd_w_o = '0;
      if ((int'(rd_row_i) < N) && (int'(rd_col_i) < N)) rd_w_o = mat_q[rd_row_i][rd_col_i];
   end

   for (genvar r = 0; r < N; r++) begin : g_row_chk
      for (genvar c = r; c < N; c++) begin : g_col_chk
         if (r == c) begin : g_diag
            a_r3_diag_zero: assert property (@(posedge clk) disable iff (!rst_n)
               mat_q[r][c] == '0);
         end else begin : g_off
            a_r3_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
               mat_q[r][c] == mat_q[c][r]);
         end
      end
   end

endmodule

// File: rtl/hebb_learn_engine.sv
module hebb_learn_engine
   import hebb_pkg::*;
#(
   parameter int N     = 8,
   parameter int W     = 4,
   parameter int ACC_W = 8,
   parameter int IDX_W = (N > 2) ? $clog2(N) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                learn_i,
   input  logic                clear_i,
   input  logic [N-1:0]        pattern_i,
   input  logic [IDX_W-1:0]    rd_row_i,
   input  logic [IDX_W-1:0]    rd_col_i,
   output logic signed [W-1:0] rd_weight_o,
   output logic                busy_o,
   output logic                osc_hold_o,
   output logic                done_o
);

   localparam int P  = pair_total(N);
   localparam int PW = (P > 1) ? $clog2(P) : 1;

   if (N < 2) begin : g_bad_n
      $error("hebb_learn_engine: N must be at least 2");
   end
   if (W < 3 || W > 5) begin : g_bad_w
      $error("hebb_learn_engine: W must be 3, 4 or 5");
   end
   if (ACC_W <= W) begin : g_bad_acc
      $error("hebb_learn_engine: ACC_W must exceed W");
   end
   if ((2 ** IDX_W) < N) begin : g_bad_idx
      $error("hebb_learn_engine: IDX_W too narrow for N");
   end

   logic                start, clr, busy;
   logic [IDX_W-1:0]    row, col;
   logic [PW-1:0]       pair;
   logic [N-1:0]        pat_q;
   logic                bit_a, bit_b;
   logic signed [W-1:0] w_nxt;

   hebb_pair_seq #(.N(N), .IDX_W(IDX_W), .PW(PW)) seq_i (
      .clk(clk), .rst_n(rst_n), .learn_i(learn_i), .clear_i(clear_i),
      .start_o(start), .clr_o(clr), .busy_o(busy), .done_o(done_o),
      .row_o(row), .col_o(col), .pair_o(pair)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pat_q <= '0;
      else if (start) pat_q <= pattern_i;
   end

   assign bit_a = (int'(row) < N) ? pat_q[row] : 1'b0;
   assign bit_b = (int'(col) < N) ? pat_q[col] : 1'b0;

   hebb_acc_bank #(.P(P), .PW(PW), .ACC_W(ACC_W), .W(W)) acc_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(busy), .pair_i(pair),
      .bit_a_i(bit_a), .bit_b_i(bit_b), .w_nxt_o(w_nxt)
   );

   hebb_weight_mat #(.N(N), .IDX_W(IDX_W), .W(W)) mat_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(busy),
      .wr_row_i(row), .wr_col_i(col), .wr_w_i(w_nxt),
      .rd_row_i(rd_row_i), .rd_col_i(rd_col_i), .rd_w_o(rd_weight_o)
   );

   assign busy_o     = busy;
   assign osc_hold_o = busy;

   // R8: a clear is never taken during an update
   a_r8_clear_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && clear_i) |=> busy_o || done_o);

endmodule

// File: tb/hebb_learn_engine_tb_top.sv
module hebb_learn_engine_tb_top;

   localparam int N = 8, W = 4, ACC_W = 8, IDX_W = 3, P = 28;
   localparam int WMAX = 7, WMIN = -8, AMAX = 127, AMIN = -128;

   logic clk = 1'b0, rst_n = 1'b0, learn = 1'b0, clear = 1'b0;
   logic [N-1:0] pattern = '0;
   logic [IDX_W-1:0] rd_row = '0, rd_col = '0;
   logic signed [W-1:0] rd_w;
   logic busy, hold, done;

   always #5 clk = ~clk;

   hebb_learn_engine #(.N(N), .W(W), .ACC_W(ACC_W), .IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .learn_i(learn), .clear_i(clear), .pattern_i(pattern),
      .rd_row_i(rd_row), .rd_col_i(rd_col), .rd_weight_o(rd_w),
      .busy_o(busy), .osc_hold_o(hold), .done_o(done)
   );

   int n_chk = 0, n_fail = 0;
   int acc_ref [N][N];
   typedef struct { int row; int col; int exp; string tag; } item_t;
   item_t exp_q[$];
   int pushed = 0, popped = 0;

   task automatic check(string tag, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int clampv(int v, int lo, int hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   function automatic void ref_clear();
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) acc_ref[r][c] = 0;
   endfunction

   // R2 / R5 reference: +1 equal bits, -1 differing, accumulator clamped
   function automatic void ref_learn(logic [N-1:0] p);
      for (int r = 0; r < N; r++)
         for (int c = r + 1; c < N; c++)
            acc_ref[r][c] = clampv(acc_ref[r][c] + ((p[r] == p[c]) ? 1 : -1), AMIN, AMAX);
   endfunction

   // driver side of the scoreboard: queue the full expected matrix
   task automatic push_all(string tag);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            item_t it;
            it.row = r;
            it.col = c;
            if (r == c)     it.exp = 0;
            else if (r < c) it.exp = clampv(acc_ref[r][c], WMIN, WMAX);
            else            it.exp = clampv(acc_ref[c][r], WMIN, WMAX);
            it.tag = (r >= c) ? "R3" : tag;
            exp_q.push_back(it);
            pushed++;
         end
      wait (popped == pushed);
   endtask

   // monitor: R9 combinational read compared against queued expectations
   initial begin
      forever begin
         item_t it;
         wait (pushed > popped);
         it = exp_q.pop_front();
         @(negedge clk);
         rd_row = IDX_W'(it.row);
         rd_col = IDX_W'(it.col);
         #1;
         check(it.tag, int'(rd_w), it.exp, $sformatf("R9 read w[%0d][%0d]", it.row, it.col));
         popped++;
      end
   end

   // inject: 0 none, 1 learn strobe mid-update, 2 clear strobe mid-update
   task automatic do_learn(logic [N-1:0] p, int inject, logic [N-1:0] p2, bit timing);
      int n;
      @(negedge clk);
      pattern = p;
      learn = 1'b1;
      @(negedge clk);
      learn = 1'b0;
      n = 0;
      while (busy) begin
         if (timing) check("R6", int'(hold), 1, "osc_hold during update");
         n++;
         if (n == 5 && inject == 1) begin
            learn = 1'b1;
            pattern = p2;
         end else if (n == 5 && inject == 2) begin
            clear = 1'b1;
         end else begin
            learn = 1'b0;
            clear = 1'b0;
         end
         @(negedge clk);
      end
      learn = 1'b0;
      clear = 1'b0;
      if (timing) begin
         check("R6", n, P, "busy cycle count");
         check("R6", int'(done), 1, "done as busy falls");
      end
      @(negedge clk);
      check(inject == 1 ? "R7" : "R6", int'(done), 0, "done single pulse");
      check(inject == 1 ? "R7" : "R6", int'(busy), 0, "no restart after done");
      ref_learn(p);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   localparam logic [N-1:0] PA = 8'b1011_0010;
   localparam logic [N-1:0] PB = 8'b0110_1100;

   initial begin
      ref_clear();
      repeat (3) @(negedge clk);
      check("R1", int'(busy), 0, "busy in reset");
      check("R1", int'(hold), 0, "hold in reset");
      check("R1", int'(done), 0, "done in reset");
      rst_n = 1'b1;
      @(negedge clk);
      push_all("R1");

      do_learn(PA, 0, '0, 1'b1);
      push_all("R2");
      do_learn(PB, 0, '0, 1'b1);
      push_all("R2");

      do_learn(PA, 1, PB, 1'b0);   // R7: mid-update learn has no effect
      push_all("R7");
      do_learn(PB, 2, '0, 1'b0);   // R8: mid-update clear ignored
      push_all("R8");

      @(negedge clk); clear = 1'b1;
      @(negedge clk); clear = 1'b0;
      check("R8", int'(busy), 0, "busy after idle clear");
      ref_clear();
      push_all("R8");

      do_learn(PA, 0, '0, 1'b0);
      @(negedge clk); clear = 1'b1; learn = 1'b1; pattern = PB;
      @(negedge clk); clear = 1'b0; learn = 1'b0;
      check("R8", int'(busy), 0, "learn dropped when clear given together");
      ref_clear();
      push_all("R8");

      repeat (9) do_learn(PA, 0, '0, 1'b0);
      push_all("R4");
      do_learn(PB, 0, '0, 1'b0);
      push_all("R4");

      @(negedge clk); clear = 1'b1;
      @(negedge clk); clear = 1'b0;
      ref_clear();
      repeat (130) do_learn(PA, 0, '0, 1'b0);
      repeat (121) do_learn(PB, 0, '0, 1'b0);
      push_all("R5");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule